// File: doc/BRIEF.md
# SCSI Block Move Phase Engine

This block carries out a single block-move command on a parallel SCSI bus, acting either as the initiator or as the target. A command word is presented together with a start pulse. The word holds a byte count and the information-transfer phase the move is meant for. In initiator role, every incoming REQ is checked against the commanded phase, and any disagreement stops the move and raises an interrupt. In target role, the block drives the phase lines itself and paces the transfer with REQ. Bytes pass one at a time between the bus and a byte-wide memory-side stream that uses valid/ready handshakes.

Two message-phase rules are built in. An attention flag, once raised, is dropped at the start of the ACK for the final byte of a message-out move. After the final byte of a message-in move, ACK stays asserted until software sends a separate clear pulse, so that the message can be inspected before the target is released. REQ, ACK and the phase lines are active-high at the ports; polarity inversion to the active-low wire levels is done in the pad ring.

Top module: `scsi_blkmove_engine`

## Requirements
- R1: After reset, busy_o, done_o, irq_o, ack_o, req_o and atn_o are low and cnt_o is zero.
- R2: cmd_i[23:0] is the byte count and cmd_i[26:24] is the phase, with bit 26 the message line, bit 25 command/data and bit 24 I/O. A start_i pulse is taken only while busy_o is low; a start_i pulse during a move has no effect on that move.
- R3: In initiator role, the phase lines are sampled on every synchronized REQ. If they differ from the commanded phase, irq_o pulses, that byte gets no ACK, busy_o falls, and cnt_o keeps the number of bytes not yet moved.
- R4: In target role, phase_o carries the commanded phase for every byte, and req_o handshakes with ack_i. When I/O is 1, the target sends data from memory; when I/O is 0, it receives data into memory.
- R5: cnt_o goes down by exactly one per completed byte. done_o pulses for one cycle when the count reaches zero, and at the same time busy_o falls. busy_o is high in the cycle after an accepted nonzero start.
- R6: A start with count zero gives a done_o pulse in the next cycle, with no handshake and no busy cycle.
- R7: In initiator role, the handshake is: wait for REQ, move the byte, raise ACK, wait for REQ to drop, lower ACK. When I/O is 1, bus bytes go to the memory stream in order; when I/O is 0, memory bytes appear on bus_data_o while ACK is high.
- R8: set_atn_i raises atn_o. In an initiator message-out move (phase 110), atn_o stays high through the ACK of every byte but the last and is low when the last ACK rises.
- R9: In an initiator message-in move (phase 111), ACK stays high after the last byte and after done_o until clr_ack_i pulses; ack_o is low in the cycle after that pulse.
- R10: A clr_ack_i that is high in the same cycle the message-in hold is taken is ignored, so the hold still forms. A clr_ack_i during a move does not disturb the per-byte ACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for cmd_i |
| cmd_i | input | 27 | Phase [26:24], byte count [23:0] |
| target_mode_i | input | 1 | 1 = act as target, 0 = initiator; sampled at start |
| set_atn_i | input | 1 | Raise attention |
| clr_ack_i | input | 1 | Release a held message-in ACK |
| busy_o | output | 1 | Move in progress |
| done_o | output | 1 | Move finished pulse |
| irq_o | output | 1 | Phase mismatch pulse |
| cnt_o | output | 24 | Bytes still to move |
| req_i | input | 1 | REQ from target (asynchronous) |
| ack_i | input | 1 | ACK from initiator (asynchronous) |
| phase_i | input | 3 | Bus phase lines seen (asynchronous) |
| req_o | output | 1 | REQ driven as target |
| ack_o | output | 1 | ACK driven as initiator |
| atn_o | output | 1 | Attention driven as initiator |
| phase_o | output | 3 | Phase lines driven as target |
| bus_data_i | input | 8 | Bus data in |
| bus_data_o | output | 8 | Bus data out |
| bus_data_oe_o | output | 1 | Bus data output enable |
| mem_rd_valid_i | input | 1 | Memory byte available |
| mem_rd_data_i | input | 8 | Memory byte |
| mem_rd_ready_o | output | 1 | Memory byte taken |
| mem_wr_valid_o | output | 1 | Byte for memory valid |
| mem_wr_data_o | output | 8 | Byte for memory |
| mem_wr_ready_i | input | 1 | Memory accepts byte |

## Verification
Two actions can land on the same clock edge: the ACK hold for the last message-in byte being taken, and a clr_ack_i pulse. To force this overlap, clr_ack_i is held high for the whole of a message-in move and is dropped only when done_o is seen, so it is high on the exact edge where the hold forms. ACK must still be high two cycles later, must fall one cycle after a fresh clear pulse, and every ACK during the move must have completed its normal handshake. The same edge-ordering question arises for attention: the timing of the atn_o drop is judged at every ACK rise of message-out moves from one to three bytes long.

// File: rtl/bm_pkg.sv
package bm_pkg;
  localparam int PH_W = 3;
  localparam logic [PH_W-1:0] PH_MSG_OUT = 3'b110;
  localparam logic [PH_W-1:0] PH_MSG_IN  = 3'b111;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PEER_HI,   // initiator: wait REQ high
    ST_MEM_RD,    // fetch byte from memory side
    ST_MEM_WR,    // push byte to memory side
    ST_OWN_HI,    // own strobe asserted
    ST_PEER_LO    // target: REQ dropped, wait ACK low
  } bm_state_e;
endpackage

// File: rtl/bm_sync.sv
module bm_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bm_byte_ctr.sv
module bm_byte_ctr #(
  parameter int CNT_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q == CNT_W'(1));

  a_r5_dec_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(cnt_q) && !$past(load_i)) |-> (cnt_q == $past(cnt_q) - CNT_W'(1)));
  a_r5_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> (cnt_q != '0));
endmodule

// File: rtl/scsi_blkmove_engine.sv
module scsi_blkmove_engine
  import bm_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [CNT_W+PH_W-1:0] cmd_i,
  input  logic                  target_mode_i,
  input  logic                  set_atn_i,
  input  logic                  clr_ack_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  irq_o,
  output logic [CNT_W-1:0]      cnt_o,
  input  logic                  req_i,
  input  logic                  ack_i,
  input  logic [PH_W-1:0]       phase_i,
  output logic                  req_o,
  output logic                  ack_o,
  output logic                  atn_o,
  output logic [PH_W-1:0]       phase_o,
  input  logic [DATA_W-1:0]     bus_data_i,
  output logic [DATA_W-1:0]     bus_data_o,
  output logic                  bus_data_oe_o,
  input  logic                  mem_rd_valid_i,
  input  logic [DATA_W-1:0]     mem_rd_data_i,
  output logic                  mem_rd_ready_o,
  output logic                  mem_wr_valid_o,
  output logic [DATA_W-1:0]     mem_wr_data_o,
  input  logic                  mem_wr_ready_i
);
  localparam int PH_LSB = CNT_W;
  localparam int SYN_W  = PH_W + 2;

  // synchronized bus inputs
  logic [SYN_W-1:0] syn_d, syn_q;
  logic             req_s, ack_s;
  logic [PH_W-1:0]  phase_s;

  assign syn_d = {req_i, ack_i, phase_i};

  bm_sync #(.WIDTH(SYN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (syn_d),
    .q_o   (syn_q)
  );

  assign {req_s, ack_s, phase_s} = syn_q;

  // command fields
  logic [PH_W-1:0]  cmd_phase;
  logic [CNT_W-1:0] cmd_cnt;
  logic             start_tx;

  assign cmd_phase = cmd_i[PH_LSB +: PH_W];
  assign cmd_cnt   = cmd_i[CNT_W-1:0];
  assign start_tx  = (cmd_phase[0] == target_mode_i);

  bm_state_e         state_q, state_d, nxt_byte;
  logic [PH_W-1:0]   phase_q;
  logic              target_q, tx_q;
  logic [DATA_W-1:0] data_q;
  logic              ack_hold_q, atn_q, done_q, irq_q;

  logic load, dec, last, finish;
  logic done_d, irq_d, cap_bus, cap_mem, atn_clr, hold_set;
  logic peer_s;

  bm_byte_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .load_val_i(cmd_cnt),
    .dec_i     (dec),
    .cnt_o     (cnt_o),
    .last_o    (last)
  );

  assign peer_s   = target_q ? ack_s : req_s;
  assign nxt_byte = target_q ? (tx_q ? ST_MEM_RD : ST_OWN_HI) : ST_PEER_HI;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    dec      = 1'b0;
    done_d   = 1'b0;
    irq_d    = 1'b0;
    cap_bus  = 1'b0;
    cap_mem  = 1'b0;
    atn_clr  = 1'b0;
    hold_set = 1'b0;
    finish   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load = 1'b1;
          if (cmd_cnt == '0)      done_d  = 1'b1;
          else if (target_mode_i) state_d = start_tx ? ST_MEM_RD : ST_OWN_HI;
          else                    state_d = ST_PEER_HI;
        end
      end
      ST_PEER_HI: begin
        if (peer_s) begin
          if (phase_s != phase_q) begin
            irq_d   = 1'b1;
            state_d = ST_IDLE;
          end else if (tx_q) begin
            state_d = ST_MEM_RD;
          end else begin
            cap_bus = 1'b1;
            state_d = ST_MEM_WR;
          end
        end
      end
      ST_MEM_RD: begin
        if (mem_rd_valid_i) begin
          cap_mem = 1'b1;
          state_d = ST_OWN_HI;
          // drop attention as the last message-out ACK goes up
          atn_clr = !target_q && last && (phase_q == PH_MSG_OUT);
        end
      end
      ST_MEM_WR: begin
        if (mem_wr_ready_i) begin
          if (target_q) finish  = 1'b1;
          else          state_d = ST_OWN_HI;
        end
      end
      ST_OWN_HI: begin
        if (target_q) begin
          if (peer_s) begin
            cap_bus = !tx_q;
            state_d = ST_PEER_LO;
          end
        end else if (!peer_s) begin
          finish   = 1'b1;
          hold_set = last && (phase_q == PH_MSG_IN);
        end
      end
      ST_PEER_LO: begin
        if (!peer_s) begin
          if (tx_q) finish  = 1'b1;
          else      state_d = ST_MEM_WR;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    if (finish) begin
      dec = 1'b1;
      if (last) begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end else begin
        state_d = nxt_byte;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      phase_q    <= '0;
      target_q   <= 1'b0;
      tx_q       <= 1'b0;
      data_q     <= '0;
      ack_hold_q <= 1'b0;
      atn_q      <= 1'b0;
      done_q     <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      irq_q   <= irq_d;
      if (load) begin
        phase_q  <= cmd_phase;
        target_q <= target_mode_i;
        tx_q     <= start_tx;
      end
      if (cap_bus)      data_q <= bus_data_i;
      else if (cap_mem) data_q <= mem_rd_data_i;
      // taking the hold wins over a same-cycle clear
      if (hold_set)       ack_hold_q <= 1'b1;
      else if (clr_ack_i) ack_hold_q <= 1'b0;
      if (set_atn_i)    atn_q <= 1'b1;
      else if (atn_clr) atn_q <= 1'b0;
    end
  end

  assign busy_o         = (state_q != ST_IDLE);
  assign done_o         = done_q;
  assign irq_o          = irq_q;
  assign req_o          = target_q && (state_q == ST_OWN_HI);
  assign ack_o          = (!target_q && (state_q == ST_OWN_HI)) || ack_hold_q;
  assign atn_o          = atn_q;
  assign phase_o        = (target_q && busy_o) ? phase_q : '0;
  assign bus_data_o     = data_q;
  assign bus_data_oe_o  = busy_o && tx_q;
  assign mem_rd_ready_o = (state_q == ST_MEM_RD);
  assign mem_wr_valid_o = (state_q == ST_MEM_WR);
  assign mem_wr_data_o  = data_q;

  a_r3_irq_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $stable(cnt_o));
  a_r5_done_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r6_zero_count_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && cmd_cnt == '0) |=> (done_o && !busy_o));
  a_r7_ack_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ack_o) && !target_q) |-> req_s);
  a_r8_atn_drop_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(atn_o) |-> (ack_o && phase_q == PH_MSG_OUT && cnt_o == CNT_W'(1)));
  a_r9_ack_hold_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_hold_q && !clr_ack_i) |=> ack_o);
endmodule

// File: tb/scsi_blkmove_engine_tb.sv
module scsi_blkmove_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 24;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic             start_i = 0, target_mode_i = 0, set_atn_i = 0, clr_ack_i = 0;
  logic [CNT_W+2:0] cmd_i = '0;
  logic             req_i = 0, ack_i = 0;
  logic [2:0]       phase_i = '0;
  logic [7:0]       bus_data_i = '0, mem_rd_data_i = '0;
  logic             mem_rd_valid_i = 1, mem_wr_ready_i = 1;
  logic             busy_o, done_o, irq_o, req_o, ack_o, atn_o, bus_data_oe_o;
  logic             mem_rd_ready_o, mem_wr_valid_o;
  logic [CNT_W-1:0] cnt_o;
  logic [2:0]       phase_o;
  logic [7:0]       bus_data_o, mem_wr_data_o;

  scsi_blkmove_engine u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .cmd_i(cmd_i),
    .target_mode_i(target_mode_i), .set_atn_i(set_atn_i), .clr_ack_i(clr_ack_i),
    .busy_o(busy_o), .done_o(done_o), .irq_o(irq_o), .cnt_o(cnt_o),
    .req_i(req_i), .ack_i(ack_i), .phase_i(phase_i), .req_o(req_o), .ack_o(ack_o),
    .atn_o(atn_o), .phase_o(phase_o), .bus_data_i(bus_data_i), .bus_data_o(bus_data_o),
    .bus_data_oe_o(bus_data_oe_o), .mem_rd_valid_i(mem_rd_valid_i),
    .mem_rd_data_i(mem_rd_data_i), .mem_rd_ready_o(mem_rd_ready_o),
    .mem_wr_valid_o(mem_wr_valid_o), .mem_wr_data_o(mem_wr_data_o),
    .mem_wr_ready_i(mem_wr_ready_i)
  );

  int   vectors = 0, fails = 0, run_id = 0;
  logic rd_rst = 1, wr_rst = 1;
  int   rd_idx = 0, wr_cnt = 0;
  logic [7:0] wr_got [16];

  function automatic logic [7:0] pat(input int r, input int i);
    return 8'((r * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // memory read side: byte index advances after each accepted read
  initial begin
    bit pend = 0;
    forever begin
      @(negedge clk);
      if (rd_rst) begin rd_idx = 0; pend = 0; end
      else begin
        if (pend) rd_idx++;
        pend = mem_rd_ready_o;
      end
      mem_rd_data_i = pat(run_id, rd_idx);
    end
  end

  // memory write side: record every pushed byte
  initial begin
    forever begin
      @(negedge clk);
      if (wr_rst) wr_cnt = 0;
      else if (mem_wr_valid_o && wr_cnt < 16) begin
        wr_got[wr_cnt] = mem_wr_data_o;
        wr_cnt++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  task automatic prep();
    run_id++;
    rd_rst = 1; wr_rst = 1;
    repeat (2) @(negedge clk);
    rd_rst = 0; wr_rst = 0;
  endtask

  task automatic start(input logic [2:0] ph, input int n, input logic tm);
    @(negedge clk);
    cmd_i = {ph, CNT_W'(n)}; target_mode_i = tm; start_i = 1;
    @(negedge clk);
    start_i = 0;
    if (n > 0) chk("R5 busy after start", 32'(busy_o), 1);
  endtask

  // bench acting as target toward an initiator DUT
  task automatic tgt_byte(input logic [2:0] ph, input logic [7:0] d, input bit hold,
                          output logic [7:0] got, output logic atn_s);
    @(negedge clk);
    phase_i = ph; bus_data_i = d;
    @(negedge clk);
    req_i = 1;
    while (!ack_o) @(negedge clk);
    got = bus_data_o; atn_s = atn_o;
    req_i = 0;
    if (!hold) while (ack_o) @(negedge clk);
  endtask

  task automatic wait_end(output bit d, output bit q);
    int t = 0;
    d = 0; q = 0;
    while (t < 5000) begin
      if (done_o) d = 1;
      if (irq_o) q = 1;
      if (d || q) break;
      @(negedge clk);
      t++;
    end
  endtask

  task automatic run_init(input logic [2:0] ph, input int n, input bit atn);
    logic [7:0] got; logic atn_s; bit d, q;
    prep();
    if (atn) begin
      @(negedge clk) set_atn_i = 1;
      @(negedge clk) set_atn_i = 0;
      chk("R8 atn raised", 32'(atn_o), 1);
    end
    start(ph, n, 0);
    for (int i = 0; i < n; i++) begin
      tgt_byte(ph, pat(run_id + 50, i), (ph == 3'b111) && (i == n - 1), got, atn_s);
      if (!ph[0]) chk("R7 data-out byte on bus", 32'(got), 32'(pat(run_id, i)));
      if (atn) chk("R8 atn at ack", 32'(atn_s), (i == n - 1) ? 0 : 1);
    end
    wait_end(d, q);
    chk("R5 done pulse", 32'(d), 1);
    chk("R5 count zero at end", 32'(cnt_o), 0);
    chk("R5 busy low at end", 32'(busy_o), 0);
    if (ph[0]) begin
      chk("R7 bytes pushed", 32'(wr_cnt), 32'(n));
      for (int i = 0; i < n; i++) chk("R7 data-in byte", 32'(wr_got[i]), 32'(pat(run_id + 50, i)));
    end
    if (ph == 3'b111) begin
      repeat (3) @(negedge clk);
      chk("R9 ack held after done", 32'(ack_o), 1);
      clr_ack_i = 1;
      @(negedge clk) clr_ack_i = 0;
      chk("R9 ack released by clear", 32'(ack_o), 0);
    end else begin
      chk("R7 ack low after move", 32'(ack_o), 0);
    end
  endtask

  // bench acting as initiator toward a target DUT
  task automatic run_tgt(input logic [2:0] ph, input int n);
    bit d, q;
    prep();
    start(ph, n, 1);
    for (int i = 0; i < n; i++) begin
      while (!req_o) @(negedge clk);
      chk("R4 phase driven", 32'(phase_o), 32'(ph));
      if (ph[0]) chk("R4 target sends byte", 32'(bus_data_o), 32'(pat(run_id, i)));
      bus_data_i = pat(run_id + 50, i);
      @(negedge clk) ack_i = 1;
      while (req_o) @(negedge clk);
      ack_i = 0;
    end
    wait_end(d, q);
    chk("R4 target done", 32'(d), 1);
    chk("R5 target count zero", 32'(cnt_o), 0);
    if (!ph[0]) begin
      chk("R4 target bytes pushed", 32'(wr_cnt), 32'(n));
      for (int i = 0; i < n; i++) chk("R4 target rx byte", 32'(wr_got[i]), 32'(pat(run_id + 50, i)));
    end
  endtask

  initial begin
    logic [7:0] got; logic atn_s; bit d, q, ack_seen;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    chk("R1 busy", 32'(busy_o), 0);
    chk("R1 done", 32'(done_o), 0);
    chk("R1 irq", 32'(irq_o), 0);
    chk("R1 ack", 32'(ack_o), 0);
    chk("R1 req", 32'(req_o), 0);
    chk("R1 atn", 32'(atn_o), 0);
    chk("R1 count", 32'(cnt_o), 0);

    // R6: zero count
    prep();
    @(negedge clk);
    cmd_i = {3'b001, CNT_W'(0)}; target_mode_i = 0; start_i = 1;
    @(negedge clk);
    start_i = 0;
    chk("R6 done next cycle", 32'(done_o), 1);
    chk("R6 never busy", 32'(busy_o), 0);
    chk("R6 no ack", 32'(ack_o), 0);
    @(negedge clk);
    chk("R6 done one cycle", 32'(done_o), 0);

    // R7 sweeps, initiator both directions
    for (int ph = 0; ph < 6; ph++)
      for (int n = 1; n <= 4; n++) run_init(3'(ph), n, 0);
    // R8 message-out with attention
    for (int n = 1; n <= 3; n++) run_init(3'b110, n, 1);
    // R9 message-in hold
    for (int n = 1; n <= 3; n++) run_init(3'b111, n, 0);
    // R4 target sweeps
    for (int ph = 0; ph < 8; ph++)
      for (int n = 1; n <= 3; n++) run_tgt(3'(ph), n);

    // R3: mismatch before any data
    prep();
    start(3'b001, 5, 0);
    @(negedge clk) phase_i = 3'b011;
    @(negedge clk) req_i = 1;
    ack_seen = 0;
    for (int t = 0; t < 50 && !irq_o; t++) begin
      if (ack_o) ack_seen = 1;
      @(negedge clk);
    end
    chk("R3 irq on first req", 32'(irq_o), 1);
    chk("R3 no ack on mismatch", 32'(ack_seen), 0);
    chk("R3 count untouched", 32'(cnt_o), 5);
    chk("R3 busy dropped", 32'(busy_o), 0);
    req_i = 0;
    repeat (4) @(negedge clk);

    // R3: mismatch in the middle of a move
    prep();
    start(3'b001, 5, 0);
    tgt_byte(3'b001, 8'h11, 0, got, atn_s);
    tgt_byte(3'b001, 8'h22, 0, got, atn_s);
    @(negedge clk) phase_i = 3'b000;
    @(negedge clk) req_i = 1;
    wait_end(d, q);
    chk("R3 mid-move irq", 32'(q), 1);
    chk("R3 mid-move remaining count", 32'(cnt_o), 3);
    chk("R3 mid-move bytes pushed", 32'(wr_cnt), 2);
    req_i = 0;
    repeat (4) @(negedge clk);

    // R2: start while busy ignored
    prep();
    start(3'b001, 3, 0);
    tgt_byte(3'b001, 8'hA0, 0, got, atn_s);
    @(negedge clk);
    cmd_i = {3'b000, CNT_W'(9)}; start_i = 1;
    @(negedge clk) start_i = 0;
    tgt_byte(3'b001, 8'hA1, 0, got, atn_s);
    tgt_byte(3'b001, 8'hA2, 0, got, atn_s);
    wait_end(d, q);
    chk("R2 done after original count", 32'(d), 1);
    chk("R2 bytes pushed", 32'(wr_cnt), 3);
    chk("R2 last byte kept", 32'(wr_got[2]), 32'h A2);

    // R10: clear held high across the cycle the hold forms
    prep();
    clr_ack_i = 1;
    start(3'b111, 2, 0);
    tgt_byte(3'b111, 8'h5A, 0, got, atn_s);
    tgt_byte(3'b111, 8'h5B, 1, got, atn_s);
    wait_end(d, q);
    clr_ack_i = 0;
    chk("R10 done with clear high", 32'(d), 1);
    repeat (2) @(negedge clk);
    chk("R10 hold survives same-cycle clear", 32'(ack_o), 1);
    clr_ack_i = 1;
    @(negedge clk) clr_ack_i = 0;
    chk("R10 later clear releases", 32'(ack_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule